// File: doc/BRIEF.md
# GHASH Tag Checker for Encrypted Memory Blocks

This unit authenticates one 64-byte memory block that arrives from off-chip memory as ciphertext. It takes the four 128-bit ciphertext chunks one at a time and builds a GHASH-style digest over them. Each step XORs the running value with the chunk and multiplies the result by a secret hash key in GF(2^128). A closing length block is then folded in with one more multiply, which keeps the digest compatible with the Galois/Counter Mode definition for a message that carries no associated data.

An AES engine outside the unit computes the authentication pad while the memory read is still in flight. It encrypts the block address, the block's counter and an initialization vector that differs from the one used for data. Once the digest is complete, only the final XOR with that pad and a compare remain. The unit truncates the digest to the configured tag width, compares it with the tag read from memory, and raises a single-cycle pass or fail strobe.

Each failed check also starts a stall request to the core. The stall gets twice as long with each further failure, which makes repeated forgery attempts very slow.

Top module: `ghash_auth_tag`

## Requirements
- R1: While reset is held and after it is released, with no block in progress, `auth_pass`, `auth_fail` and `stall` are all low.
- R2: Each accepted chunk C updates the accumulator to (A xor C)·H in GF(2^128), using the polynomial x^128 + x^7 + x^2 + x + 1 and the GCM bit order. Bit 127 of a vector is the coefficient of x^0, so multiplying by the vector with only bit 127 set returns the other operand. Chunks may come back to back or with idle cycles between them, and each update takes one cycle.
- R3: After the fourth chunk, the unit folds in the length block {64'd0, 64'd512} with one more multiply by H. It then XORs the digest with `auth_pad`, so a wrong pad makes the check fail.
- R4: The tag is bits 127 down to 128-TAG_W of the padded digest, with TAG_W = 64 by default (32 and 128 also allowed). `auth_pad` carries those same upper pad bits. A mismatch in any tag bit, lowest or highest, gives a fail.
- R5: The result strobe (`auth_pass` or `auth_fail`, never both) is high for exactly one cycle. That cycle follows the second rising edge after the edge that captures the fourth chunk.
- R6: The accumulator starts from zero for every block. A block that starts in the result cycle of the previous block gets the same result as it would in isolation.
- R7: `chunk_valid` is ignored during the two cycles after the fourth chunk, while the length fold and the compare take place.
- R8: On the n-th failure since reset, `stall` goes high in the same cycle as `auth_fail` and stays high for STALL_BASE·2^min(n-1, MAX_DOUBLINGS) cycles (4, 8, 16, … by default). A pass does not reset the failure count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the unit |
| hash_key | input | 128 | GHASH key H, held stable for the whole block |
| chunk_valid | input | 1 | A ciphertext chunk is present on `chunk_data` |
| chunk_data | input | 128 | Ciphertext chunk, in block order |
| auth_pad | input | TAG_W | Upper TAG_W bits of the authentication pad, stable from the fourth chunk to the result |
| stored_tag | input | TAG_W | Tag read from memory, stable from the fourth chunk to the result |
| auth_pass | output | 1 | One-cycle strobe: the computed tag matches |
| auth_fail | output | 1 | One-cycle strobe: the computed tag differs |
| stall | output | 1 | Stall request after a failure, with a length that doubles on each failure |

## Verification
The result strobe is due two rising edges after the fourth chunk is captured. The bench drives inputs on falling edges and reads the strobe on the third falling edge after driving the last chunk. It also checks that the strobe is low on the two falling edges before that one and on the one after it. The stall length is measured by counting the falling edges with `stall` high, starting at that same result edge, and this count is compared with the doubling length the bench tracks. For a block that starts in the result cycle, the bench reads the first result before driving the new chunk on the same falling edge.

// File: rtl/ghash_pkg.sv
`timescale 1ns/1ps
package ghash_pkg;
  typedef logic [127:0] blk_t;

  // Reduction constant for x^128 + x^7 + x^2 + x + 1 in reflected (GCM) order.
  localparam blk_t GF_RED = {8'hE1, 120'h0};
  // Multiplicative identity: coefficient of x^0 sits in bit 127.
  localparam blk_t GF_ONE = {1'b1, 127'h0};

  typedef enum logic [1:0] {
    PH_ABSORB = 2'd0,
    PH_FOLD   = 2'd1,
    PH_FINISH = 2'd2
  } phase_t;
endpackage

// File: rtl/ghash_gfmul.sv
`timescale 1ns/1ps
module ghash_gfmul
  import ghash_pkg::*;
(
  input  blk_t x_i,
  input  blk_t y_i,
  output blk_t z_o
);
  // Shift-and-add product, scanning x from the x^0 coefficient (bit 127).
  always_comb begin
    blk_t v;
    blk_t sum;
    v   = y_i;
    sum = '0;
    for (int i = 0; i < 128; i++) begin
      if (x_i[127-i]) sum = sum ^ v;
      if (v[0]) v = (v >> 1) ^ GF_RED;
      else      v = v >> 1;
    end
    z_o = sum;
  end
endmodule

// File: rtl/ghash_chain.sv
`timescale 1ns/1ps
module ghash_chain
  import ghash_pkg::*;
#(
  parameter int CHUNKS = 4,
  parameter int TAG_W  = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  blk_t             key_i,
  input  logic             in_valid,
  input  blk_t             in_data,
  output logic [TAG_W-1:0] digest_hi,
  output logic             digest_ready
);
  localparam int   CW       = $clog2(CHUNKS);
  localparam int   MSG_BITS = CHUNKS * 128;
  localparam blk_t LEN_BLK  = {64'd0, 64'(MSG_BITS)};
  localparam logic [CW-1:0] LAST = CW'(CHUNKS - 1);

  phase_t        phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d;
  blk_t          acc_q;
  blk_t          mul_in, mul_out;
  logic          take, acc_en;

  assign take   = (phase_q == PH_ABSORB) && in_valid;
  assign acc_en = take || (phase_q == PH_FOLD);

  always_comb begin
    if (phase_q == PH_FOLD)
      mul_in = acc_q ^ LEN_BLK;
    else
      mul_in = ((cnt_q == '0) ? '0 : acc_q) ^ in_data;
  end

  ghash_gfmul u_mul (.x_i(mul_in), .y_i(key_i), .z_o(mul_out));

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    unique case (phase_q)
      PH_ABSORB: if (take) begin
        if (cnt_q == LAST) begin
          cnt_d   = '0;
          phase_d = PH_FOLD;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      PH_FOLD:   phase_d = PH_FINISH;
      PH_FINISH: phase_d = PH_ABSORB;
      default:   phase_d = PH_ABSORB;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_ABSORB;
      cnt_q   <= '0;
      acc_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      if (acc_en) acc_q <= mul_out;
    end
  end

  assign digest_hi    = acc_q[127 -: TAG_W];
  assign digest_ready = (phase_q == PH_FINISH);

  // R2: first chunk times the identity key lands unchanged in the accumulator
  assert_identity_mul_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cnt_q == '0 && key_i == GF_ONE) |=> (acc_q == $past(in_data)));
  // R3: the last chunk is always followed by the length fold
  assert_len_fold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cnt_q == LAST) |=> (phase_q == PH_FOLD));
  // R7: no chunk is counted while folding or comparing
  assert_busy_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_ABSORB) |=> $stable(cnt_q));
endmodule

// File: rtl/ghash_tag_check.sv
`timescale 1ns/1ps
module ghash_tag_check #(
  parameter int TAG_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             check_en,
  input  logic [TAG_W-1:0] digest_hi,
  input  logic [TAG_W-1:0] pad_hi,
  input  logic [TAG_W-1:0] expect_tag,
  output logic             pass_o,
  output logic             fail_o,
  output logic             fail_evt
);
  logic [TAG_W-1:0] tag_calc;
  logic             match;
  logic             pass_d, fail_d;

  generate
    if (TAG_W != 32 && TAG_W != 64 && TAG_W != 128) begin : g_bad_width
      $error("ghash_tag_check: TAG_W must be 32, 64 or 128");
    end
  endgenerate

  assign tag_calc = digest_hi ^ pad_hi;
  assign match    = (tag_calc == expect_tag);

  always_comb begin
    pass_d = check_en && match;
    fail_d = check_en && !match;
  end

  assign fail_evt = fail_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pass_o <= 1'b0;
      fail_o <= 1'b0;
    end else begin
      pass_o <= pass_d;
      fail_o <= fail_d;
    end
  end

  // R5: a verdict lasts one cycle only
  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_o || fail_o) |=> !(pass_o || fail_o));
  // R5: never pass and fail together
  assert_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pass_o, fail_o}));
endmodule

// File: rtl/ghash_backoff.sv
`timescale 1ns/1ps
module ghash_backoff #(
  parameter int STALL_BASE    = 4,
  parameter int MAX_DOUBLINGS = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fail_evt,
  output logic stall_o
);
  localparam int LONGEST = STALL_BASE << MAX_DOUBLINGS;
  localparam int CNT_W   = $clog2(LONGEST + 1);
  localparam int SH_W    = (MAX_DOUBLINGS > 0) ? $clog2(MAX_DOUBLINGS + 1) : 1;
  localparam logic [SH_W-1:0] SH_MAX = SH_W'(MAX_DOUBLINGS);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [SH_W-1:0]  nfail_q, nfail_d;
  logic [CNT_W-1:0] load_len;

  assign load_len = CNT_W'(STALL_BASE) << nfail_q;

  always_comb begin
    cnt_d   = cnt_q;
    nfail_d = nfail_q;
    if (fail_evt) begin
      cnt_d = load_len;
      if (nfail_q != SH_MAX) nfail_d = nfail_q + SH_W'(1);
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      nfail_q <= '0;
    end else begin
      cnt_q   <= cnt_d;
      nfail_q <= nfail_d;
    end
  end

  assign stall_o = (cnt_q != '0);

  // R8: a failure starts the stall in the same cycle the verdict appears
  assert_stall_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fail_evt |=> stall_o);
  // R8: without a new failure the window shrinks by one per cycle
  assert_countdown_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!fail_evt && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
  // R8: doubling count saturates
  assert_dbl_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    nfail_q <= SH_MAX);
endmodule

// File: rtl/ghash_auth_tag.sv
`timescale 1ns/1ps
module ghash_auth_tag
  import ghash_pkg::*;
#(
  parameter int TAG_W         = 64,
  parameter int CHUNKS        = 4,
  parameter int STALL_BASE    = 4,
  parameter int MAX_DOUBLINGS = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [127:0]     hash_key,
  input  logic             chunk_valid,
  input  logic [127:0]     chunk_data,
  input  logic [TAG_W-1:0] auth_pad,
  input  logic [TAG_W-1:0] stored_tag,
  output logic             auth_pass,
  output logic             auth_fail,
  output logic             stall
);
  logic             rst_meta, rst_ok;
  logic [TAG_W-1:0] digest_hi;
  logic             digest_ready;
  logic             fail_evt;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_ok   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_ok   <= rst_meta;
    end
  end

  ghash_chain #(.CHUNKS(CHUNKS), .TAG_W(TAG_W)) u_chain (
    .clk          (clk),
    .rst_n        (rst_ok),
    .key_i        (hash_key),
    .in_valid     (chunk_valid),
    .in_data      (chunk_data),
    .digest_hi    (digest_hi),
    .digest_ready (digest_ready)
  );

  ghash_tag_check #(.TAG_W(TAG_W)) u_check (
    .clk        (clk),
    .rst_n      (rst_ok),
    .check_en   (digest_ready),
    .digest_hi  (digest_hi),
    .pad_hi     (auth_pad),
    .expect_tag (stored_tag),
    .pass_o     (auth_pass),
    .fail_o     (auth_fail),
    .fail_evt   (fail_evt)
  );

  ghash_backoff #(.STALL_BASE(STALL_BASE), .MAX_DOUBLINGS(MAX_DOUBLINGS)) u_backoff (
    .clk      (clk),
    .rst_n    (rst_ok),
    .fail_evt (fail_evt),
    .stall_o  (stall)
  );

  // R1: quiet outputs while the unit is held in reset
  assert_quiet_reset_R1: assert property (@(posedge clk)
    !rst_ok |=> !(auth_pass || auth_fail || stall));
endmodule

// File: tb/ghash_auth_tag_test.sv
`timescale 1ns/1ps
module ghash_auth_tag_test;
  localparam int PERIOD = 10;
  localparam int TW     = 64;
  localparam logic [127:0] LEN_BLK = {64'd0, 64'd512};
  localparam logic [127:0] ONE     = {1'b1, 127'h0};

  logic           clk = 1'b0;
  logic           rst_n;
  logic [127:0]   hash_key;
  logic           chunk_valid;
  logic [127:0]   chunk_data;
  logic [TW-1:0]  auth_pad;
  logic [TW-1:0]  stored_tag;
  logic           auth_pass, auth_fail, stall;

  int n_checks = 0;
  int n_fails  = 0;
  int fails_seen = 0;

  always #(PERIOD/2) clk = ~clk;

  ghash_auth_tag #(.TAG_W(TW), .CHUNKS(4), .STALL_BASE(4), .MAX_DOUBLINGS(6)) uut (
    .clk(clk), .rst_n(rst_n), .hash_key(hash_key), .chunk_valid(chunk_valid),
    .chunk_data(chunk_data), .auth_pad(auth_pad), .stored_tag(stored_tag),
    .auth_pass(auth_pass), .auth_fail(auth_fail), .stall(stall)
  );

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Horner-form field product: walk a from its highest-degree coefficient (bit 0).
  function automatic logic [127:0] fmul(input logic [127:0] a, input logic [127:0] b);
    logic [127:0] z = '0;
    for (int j = 0; j < 128; j++) begin
      z = z[0] ? ((z >> 1) ^ {8'hE1, 120'h0}) : (z >> 1);
      if (a[j]) z = z ^ b;
    end
    return z;
  endfunction

  function automatic logic [TW-1:0] model_tag(input logic [127:0] h, input logic [127:0] c [4],
                                              input logic [TW-1:0] pad);
    logic [127:0] y = '0;
    for (int i = 0; i < 4; i++) y = fmul(y ^ c[i], h);
    y = fmul(y ^ LEN_BLK, h);
    return y[127 -: TW] ^ pad;
  endfunction

  function automatic logic [127:0] pat(input int s);
    logic [31:0] w = 32'(s) * 32'h9E3779B9 + 32'h7F4A7C15;
    return {w, w ^ 32'h85EBCA6B, ~w, {w[15:0], w[31:16]}};
  endfunction

  function automatic int exp_stall_len();
    int sh = (fails_seen < 6) ? fails_seen : 6;
    return 4 << sh;
  endfunction

  task automatic idle_inputs();
    chunk_valid = 1'b0;
    chunk_data  = '0;
  endtask

  // Reads result strobes at result edge, checks quiet edges around it, measures stall.
  task automatic collect_result(input bit exp_pass, input string req);
    int slen;
    int exp_len;
    check(auth_pass == exp_pass, {req, " R5 pass strobe"}, 128'(auth_pass), 128'(exp_pass));
    check(auth_fail == !exp_pass, {req, " R5 fail strobe"}, 128'(auth_fail), 128'(!exp_pass));
    if (exp_pass) exp_len = 0;
    else begin
      exp_len = exp_stall_len();
      fails_seen++;
    end
    slen = stall ? 1 : 0;
    @(negedge clk);
    check(!auth_pass && !auth_fail, {req, " R5 strobe lasts one cycle"},
          128'({auth_pass, auth_fail}), 128'(0));
    while (stall && slen < 5000) begin
      slen++;
      @(negedge clk);
    end
    check(slen == exp_len, {req, " R8 stall length"}, 128'(slen), 128'(exp_len));
  endtask

  task automatic run_block(input logic [127:0] key, input logic [127:0] c [4],
                           input logic [TW-1:0] pad, input logic [TW-1:0] tag,
                           input int gap, input bit extra, input bit exp_pass, input string req);
    @(negedge clk);
    hash_key = key; auth_pad = pad; stored_tag = tag;
    for (int i = 0; i < 4; i++) begin
      chunk_valid = 1'b1;
      chunk_data  = c[i];
      @(negedge clk);
      if (i < 3) begin
        chunk_valid = 1'b0;
        chunk_data  = pat(900 + i);
        repeat (gap) @(negedge clk);
      end
    end
    // first edge after the last chunk: fold in progress
    chunk_valid = extra; chunk_data = pat(777);
    check(!auth_pass && !auth_fail, {req, " R5 no early strobe (fold)"},
          128'({auth_pass, auth_fail}), 128'(0));
    @(negedge clk);
    chunk_valid = extra; chunk_data = pat(778);
    check(!auth_pass && !auth_fail, {req, " R5 no early strobe (compare)"},
          128'({auth_pass, auth_fail}), 128'(0));
    @(negedge clk);
    idle_inputs();
    collect_result(exp_pass, req);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; hash_key = '0; auth_pad = '0; stored_tag = '0;
    idle_inputs();
    repeat (3) @(negedge clk);
    check(!auth_pass && !auth_fail && !stall, "R1 outputs quiet in reset",
          128'({auth_pass, auth_fail, stall}), 128'(0));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!auth_pass && !auth_fail && !stall, "R1 outputs quiet after reset",
          128'({auth_pass, auth_fail, stall}), 128'(0));
  endtask

  // With H = identity the digest is the XOR of all chunks and the length block.
  task automatic t_identity_key();
    logic [127:0] c [4];
    logic [127:0] x;
    logic [TW-1:0] pad = 64'h0123_4567_89AB_CDEF;
    for (int i = 0; i < 4; i++) c[i] = pat(10 + i);
    x = c[0] ^ c[1] ^ c[2] ^ c[3] ^ LEN_BLK;
    run_block(ONE, c, pad, x[127 -: TW] ^ pad, 0, 1'b0, 1'b1, "R2 R3 identity key");
  endtask

  task automatic t_random_pass(input int seed, input int gap, input string req);
    logic [127:0] c [4];
    logic [127:0] key = pat(seed) ^ {pat(seed + 50)[63:0], pat(seed + 51)[63:0]};
    logic [TW-1:0] pad = pat(seed + 7)[TW-1:0];
    for (int i = 0; i < 4; i++) c[i] = pat(seed + 20 + i);
    run_block(key, c, pad, model_tag(key, c, pad), gap, 1'b0, 1'b1, req);
  endtask

  task automatic t_tag_bit_fail(input int bitpos, input string req);
    logic [127:0] c [4];
    logic [127:0] key = pat(300);
    logic [TW-1:0] pad = pat(301)[TW-1:0];
    logic [TW-1:0] good;
    for (int i = 0; i < 4; i++) c[i] = pat(310 + i);
    good = model_tag(key, c, pad);
    run_block(key, c, pad, good ^ (TW'(1) << bitpos), 0, 1'b0, 1'b0, req);
  endtask

  task automatic t_wrong_pad();
    logic [127:0] c [4];
    logic [127:0] key = pat(400);
    logic [TW-1:0] pad = pat(401)[TW-1:0];
    for (int i = 0; i < 4; i++) c[i] = pat(410 + i);
    run_block(key, c, pad ^ {1'b1, {(TW-1){1'b0}}}, model_tag(key, c, pad), 0, 1'b0, 1'b0,
              "R3 pad mismatch fails");
  endtask

  task automatic t_extra_valid();
    logic [127:0] c [4];
    logic [127:0] key = pat(500);
    logic [TW-1:0] pad = pat(501)[TW-1:0];
    for (int i = 0; i < 4; i++) c[i] = pat(510 + i);
    run_block(key, c, pad, model_tag(key, c, pad), 0, 1'b1, 1'b1, "R7 valid ignored while busy");
    // a following block must still be aligned to its own first chunk
    t_random_pass(520, 0, "R7 next block aligned");
  endtask

  // Block B begins in the result cycle of block A.
  task automatic t_back_to_back();
    logic [127:0] a [4];
    logic [127:0] b [4];
    logic [127:0] ka = pat(600);
    logic [127:0] kb = pat(601);
    logic [TW-1:0] pa = pat(602)[TW-1:0];
    logic [TW-1:0] pb = pat(603)[TW-1:0];
    for (int i = 0; i < 4; i++) begin
      a[i] = pat(610 + i);
      b[i] = pat(620 + i);
    end
    @(negedge clk);
    hash_key = ka; auth_pad = pa; stored_tag = model_tag(ka, a, pa);
    for (int i = 0; i < 4; i++) begin
      chunk_valid = 1'b1; chunk_data = a[i];
      @(negedge clk);
    end
    idle_inputs();
    @(negedge clk);
    @(negedge clk);
    check(auth_pass && !auth_fail, "R6 first block verdict", 128'({auth_pass, auth_fail}), 128'(2'b10));
    hash_key = kb; auth_pad = pb; stored_tag = model_tag(kb, b, pb);
    for (int i = 0; i < 4; i++) begin
      chunk_valid = 1'b1; chunk_data = b[i];
      @(negedge clk);
      if (i == 0)
        check(!auth_pass && !auth_fail, "R6 strobe gone while second block streams",
              128'({auth_pass, auth_fail}), 128'(0));
    end
    idle_inputs();
    @(negedge clk);
    @(negedge clk);
    collect_result(1'b1, "R6 second block fresh accumulator");
  endtask

  initial begin
    #(PERIOD * 150000);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    t_reset();
    t_identity_key();
    t_random_pass(100, 0, "R2 R4 back-to-back chunks");
    t_random_pass(200, 3, "R2 chunks with idle gaps");
    t_tag_bit_fail(0, "R4 R8 lowest tag bit wrong, first failure");
    t_wrong_pad();
    t_tag_bit_fail(TW - 1, "R4 R8 highest tag bit wrong, third failure");
    t_extra_valid();
    t_back_to_back();
    t_tag_bit_fail(5, "R8 pass keeps count, fourth failure");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule